// File: doc/BRIEF.md
# Serial Threshold Offset Loader

This block holds the two thresholds that a FIFO's almost-empty and almost-full flag logic compares against. Both thresholds are loaded through a one-bit serial port: a serial clock, a data bit, and two active-low strobes (`ldN`, `senN`). Together the two thresholds form one shift chain, and the chain is accepted only as a complete set. A partial load can be paused at any bit and resumed later. Once the final bit arrives, both held offsets change in the same serial clock edge.

A `wideMode` input selects how long the chain is. In narrow mode each offset carries `W` bits. In wide mode each offset carries `W-1` bits, the chain is two bits shorter, and the top bit of each output reads zero. Each flag domain has its own validity output. `afValid` belongs to the write clock domain and `aeValid` to the read clock domain. Both drop after a new chain starts and rise a fixed three edges of their own clock after the chain completes.

Top module: `flag_offset_loader`

## Requirements
- R1: A bit is taken on a rising `sClk` edge only when `ldN` and `senN` are both 0. Edges with `ldN`=1, with `senN`=1, or with both at 1 shift nothing and do not advance the position.
- R2: In narrow mode (`wideMode`=0) the chain is 2·W bits long. The first bit is bit 0 of `aeOffset`, bits continue upward through `aeOffset`, then run from bit 0 to bit W-1 of `afOffset`.
- R3: In wide mode (`wideMode`=1) the chain is 2·W-2 bits long in the same order, with W-1 bits per offset. Bit W-1 of each output reads 0.
- R4: `aeOffset` and `afOffset` change only on the `sClk` edge that takes the last bit of a chain. A partial chain leaves the previous values on the outputs.
- R5: After an interruption, loading resumes at the next bit in sequence, not at the start of the chain.
- R6: `afValid` rises on the third rising `wClk` edge after the completing `sClk` edge. `aeValid` rises on the third rising `rClk` edge after that same edge.
- R7: The first bit of a new chain makes both valid outputs fall within three edges of their own clock. They stay low until that chain completes.
- R8: An active-low `rstN` clears both offsets, both valid outputs and the chain position. After each complete chain the position returns to the start, so the next chain begins at bit 0 of `aeOffset`.
- R9: A complete new chain may be loaded at any later time, and it replaces both offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low master reset, all domains |
| sClk | input | 1 | Serial clock |
| sData | input | 1 | Serial data bit |
| ldN | input | 1 | Load strobe, active low |
| senN | input | 1 | Serial enable, active low |
| wideMode | input | 1 | 1 = W-1 bits per offset, 0 = W bits per offset |
| wClk | input | 1 | Write clock domain (almost-full side) |
| rClk | input | 1 | Read clock domain (almost-empty side) |
| aeOffset | output | W | Held almost-empty threshold |
| afOffset | output | W | Held almost-full threshold |
| afValid | output | 1 | Almost-full threshold valid, `wClk` domain |
| aeValid | output | 1 | Almost-empty threshold valid, `rClk` domain |

## Verification
The most likely internal fault is a chain position that is off by one or does not wrap to zero. That fault shows on the outputs at the next completion: bits land one place over in the held offsets, or the commit arrives a bit early or late. An exhaustive sweep of every offset pair in both modes exposes this on the first wrong load. A bad skip index in wide mode puts a one in an output MSB, or drops a bit from the almost-full field. A wrong synchronizer depth shifts the valid edges by whole clock periods, and edge-exact sampling in both domains catches that.

// File: rtl/flo_pkg.sv
`timescale 1ns/100ps
package flo_pkg;
  // strobes from the serial control to the chain datapath
  typedef struct packed {
    logic shiftEn;  // take one bit this edge
    logic commit;   // this edge completes the chain
    logic wide;     // W-1 bits per offset
  } flo_strobe_t;
endpackage

// File: rtl/flo_ctrl.sv
`timescale 1ns/100ps
module flo_ctrl
  import flo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              sClk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              senN,
  input  logic              wideMode,
  output flo_strobe_t       stb,
  output logic [$clog2(2*W)-1:0] wrIdx,
  output logic              cfgDone
);
  localparam int CHAIN = 2 * W;
  localparam int CW    = $clog2(CHAIN);

  logic [CW-1:0] pos;
  logic [CW-1:0] lastPos;

  always_comb begin
    lastPos     = wideMode ? CW'(CHAIN - 3) : CW'(CHAIN - 1);
    stb.shiftEn = !ldN && !senN;
    stb.commit  = stb.shiftEn && (pos == lastPos);
    stb.wide    = wideMode;
    // wide mode skips the unused top bit of the almost-empty field
    wrIdx = (wideMode && (pos >= CW'(W - 1))) ? pos + 1'b1 : pos;
  end

  always_ff @(posedge sClk or negedge rstN) begin
    if (!rstN) begin
      pos     <= '0;
      cfgDone <= 1'b0;
    end else if (stb.shiftEn) begin
      pos <= stb.commit ? '0 : pos + 1'b1;
      if (stb.commit)
        cfgDone <= 1'b1;
      else if (pos == '0)
        cfgDone <= 1'b0;
    end
  end
endmodule

// File: rtl/flo_datapath.sv
`timescale 1ns/100ps
module flo_datapath
  import flo_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              sClk,
  input  logic              rstN,
  input  logic              sData,
  input  flo_strobe_t       stb,
  input  logic [$clog2(2*W)-1:0] wrIdx,
  output logic [W-1:0]      aeOffset,
  output logic [W-1:0]      afOffset
);
  localparam int CHAIN = 2 * W;

  logic [CHAIN-1:0] chain;
  logic [CHAIN-1:0] nextChain;

  always_comb begin
    nextChain = chain;
    if (stb.shiftEn)
      nextChain[wrIdx] = sData;
  end

  always_ff @(posedge sClk or negedge rstN) begin
    if (!rstN) begin
      chain    <= '0;
      aeOffset <= '0;
      afOffset <= '0;
    end else begin
      chain <= nextChain;
      if (stb.commit) begin
        if (stb.wide) begin
          aeOffset <= {1'b0, nextChain[W-2:0]};
          afOffset <= {1'b0, nextChain[CHAIN-2:W]};
        end else begin
          aeOffset <= nextChain[W-1:0];
          afOffset <= nextChain[CHAIN-1:W];
        end
      end
    end
  end
endmodule

// File: rtl/flo_sync.sv
`timescale 1ns/100ps
module flo_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sr <= '0;
    else       sr <= {sr[STAGES-2:0], din};
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/flag_offset_loader.sv
`timescale 1ns/100ps
module flag_offset_loader
  import flo_pkg::*;
#(
  parameter int W         = 8,
  parameter int SYNC_EDGE = 3
) (
  input  logic         rstN,
  input  logic         sClk,
  input  logic         sData,
  input  logic         ldN,
  input  logic         senN,
  input  logic         wideMode,
  input  logic         wClk,
  input  logic         rClk,
  output logic [W-1:0] aeOffset,
  output logic [W-1:0] afOffset,
  output logic         afValid,
  output logic         aeValid
);
  localparam int CW = $clog2(2 * W);

  flo_strobe_t   stb;
  logic [CW-1:0] wrIdx;
  logic          cfgDone;
  logic [1:0]    domClk;
  logic [1:0]    domValid;

  flo_ctrl #(.W(W)) u_ctrl (
    .sClk(sClk), .rstN(rstN), .ldN(ldN), .senN(senN), .wideMode(wideMode),
    .stb(stb), .wrIdx(wrIdx), .cfgDone(cfgDone)
  );

  flo_datapath #(.W(W)) u_dp (
    .sClk(sClk), .rstN(rstN), .sData(sData), .stb(stb), .wrIdx(wrIdx),
    .aeOffset(aeOffset), .afOffset(afOffset)
  );

  // domain 0 = write clock (almost-full), domain 1 = read clock (almost-empty)
  assign domClk = {rClk, wClk};

  for (genvar g = 0; g < 2; g++) begin : g_dom
    flo_sync #(.STAGES(SYNC_EDGE)) u_sync (
      .clk(domClk[g]), .rstN(rstN), .din(cfgDone), .dout(domValid[g])
    );
  end

  assign afValid = domValid[0];
  assign aeValid = domValid[1];
endmodule

// File: rtl/flo_checker.sv
`timescale 1ns/100ps
module flo_checker #(
  parameter int W = 8
) (
  input logic         rstN,
  input logic         sClk,
  input logic         ldN,
  input logic         senN,
  input logic         wClk,
  input logic         rClk,
  input logic         cfgDone,
  input logic [W-1:0] aeOffset,
  input logic [W-1:0] afOffset,
  input logic         afValid,
  input logic         aeValid
);
  // R1 / R4: an edge that takes no bit cannot move the held offsets
  a_r4_hold_offsets: assert property (@(posedge sClk) disable iff (!rstN)
    ($past(ldN) || $past(senN)) |-> ($stable(aeOffset) && $stable(afOffset)));

  // R6: rise in write domain traces to completion three edges earlier
  a_r6_af_rise: assert property (@(posedge wClk) disable iff (!rstN)
    $rose(afValid) |-> $past(cfgDone, 3));

  // R6: rise in read domain traces to completion three edges earlier
  a_r6_ae_rise: assert property (@(posedge rClk) disable iff (!rstN)
    $rose(aeValid) |-> $past(cfgDone, 3));

  // R7: fall in write domain traces to a started chain
  a_r7_af_fall: assert property (@(posedge wClk) disable iff (!rstN)
    $fell(afValid) |-> !$past(cfgDone, 3));

  // R7: fall in read domain traces to a started chain
  a_r7_ae_fall: assert property (@(posedge rClk) disable iff (!rstN)
    $fell(aeValid) |-> !$past(cfgDone, 3));
endmodule

bind flag_offset_loader flo_checker #(.W(W)) u_chk (
  .rstN(rstN), .sClk(sClk), .ldN(ldN), .senN(senN), .wClk(wClk), .rClk(rClk),
  .cfgDone(cfgDone), .aeOffset(aeOffset), .afOffset(afOffset),
  .afValid(afValid), .aeValid(aeValid)
);

// File: tb/flag_offset_loader_tb.sv
`timescale 1ns/100ps
module flag_offset_loader_tb;
  localparam int W = 4;

  logic rstN, sClk, sData, ldN, senN, wideMode, wClk, rClk;
  logic [W-1:0] aeOffset, afOffset;
  logic afValid, aeValid;
  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  flag_offset_loader #(.W(W)) u_dut (
    .rstN(rstN), .sClk(sClk), .sData(sData), .ldN(ldN), .senN(senN),
    .wideMode(wideMode), .wClk(wClk), .rClk(rClk),
    .aeOffset(aeOffset), .afOffset(afOffset), .afValid(afValid), .aeValid(aeValid)
  );

  initial wClk = 0;
  always #5 wClk = ~wClk;   // 100 MHz write clock
  initial rClk = 0;
  always #7 rClk = ~rClk;   // slower read clock

  task automatic chk(input string tag, input int got, input int exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    end
  endtask

  function automatic logic [2*W-1:0] packBits(input int ae, input int af, input bit wd);
    int n = wd ? W - 1 : W;
    logic [2*W-1:0] r = '0;
    for (int i = 0; i < n; i++) begin
      r[i]     = ae[i];
      r[n + i] = af[i];
    end
    return r;
  endfunction

  task automatic sbit(input logic b);
    sData = b; ldN = 0; senN = 0;
    #3 sClk = 1;
    #3 sClk = 0;
  endtask

  // an sClk pulse with strobes not both low: must shift nothing (R1)
  task automatic junk(input logic l, input logic s, input logic b);
    sData = b; ldN = l; senN = s;
    #3 sClk = 1;
    #3 sClk = 0;
  endtask

  task automatic loadChain(input int ae, input int af, input bit wd, input bit timing, input int from);
    int tot = wd ? 2 * W - 2 : 2 * W;
    logic [2*W-1:0] bits = packBits(ae, af, wd);
    wideMode = wd;
    for (int i = from; i < tot - 1; i++) sbit(bits[i]);
    sData = bits[tot - 1]; ldN = 0; senN = 0;
    #3 sClk = 1;
    if (timing) begin
      fork
        begin #3 sClk = 0; end
        begin
          repeat (2) @(posedge wClk);
          #1 chk("R6 afValid low before 3rd wClk edge", afValid, 0);
          @(posedge wClk);
          #1 chk("R6 afValid high on 3rd wClk edge", afValid, 1);
        end
        begin
          repeat (2) @(posedge rClk);
          #1 chk("R6 aeValid low before 3rd rClk edge", aeValid, 0);
          @(posedge rClk);
          #1 chk("R6 aeValid high on 3rd rClk edge", aeValid, 1);
        end
      join
      #0.5;
    end else begin
      #3 sClk = 0;
    end
  endtask

  initial begin
    #500000;
    nBad++;
    $display("FAIL R6 watchdog expired got 0 exp 1");
    summary();
    $finish;
  end

  initial begin
    logic [2*W-1:0] b;
    rstN = 0; sClk = 0; sData = 0; ldN = 1; senN = 1; wideMode = 0;
    #10;
    chk("R8 reset aeOffset", aeOffset, 0);
    chk("R8 reset afOffset", afOffset, 0);
    chk("R8 reset afValid", afValid, 0);
    chk("R8 reset aeValid", aeValid, 0);
    #10.5 rstN = 1;

    // first load with edge-exact validity timing
    loadChain(3, 12, 0, 1, 0);
    chk("R2 first load aeOffset", aeOffset, 3);
    chk("R2 first load afOffset", afOffset, 12);

    // R7: first bit of a new chain drops validity, offsets held (R4)
    b = packBits(6, 9, 0);
    sbit(b[0]);
    chk("R4 partial keeps aeOffset", aeOffset, 3);
    chk("R4 partial keeps afOffset", afOffset, 12);
    repeat (3) @(posedge wClk);
    #1 chk("R7 afValid low after chain start", afValid, 0);
    repeat (3) @(posedge rClk);
    #1 chk("R7 aeValid low after chain start", aeValid, 0);
    #0.5;
    loadChain(6, 9, 0, 1, 1);
    chk("R9 reprogram aeOffset", aeOffset, 6);
    chk("R9 reprogram afOffset", afOffset, 9);

    // R5 / R1: interruption mid-chain with blocked edges
    b = packBits(13, 2, 0);
    for (int i = 0; i < 3; i++) sbit(b[i]);
    junk(0, 1, ~b[3]);
    junk(1, 0, ~b[3]);
    junk(1, 1, ~b[3]);
    chk("R4 interrupted keeps aeOffset", aeOffset, 6);
    chk("R4 interrupted keeps afOffset", afOffset, 9);
    loadChain(13, 2, 0, 0, 3);
    chk("R5 resumed aeOffset", aeOffset, 13);
    chk("R1 blocked edges afOffset", afOffset, 2);

    // R3: wide mode with timing
    loadChain(5, 7, 1, 1, 0);
    chk("R3 wide aeOffset", aeOffset, 5);
    chk("R3 wide afOffset", afOffset, 7);

    // exhaustive narrow sweep
    for (int ae = 0; ae < 16; ae++)
      for (int af = 0; af < 16; af++) begin
        loadChain(ae, af, 0, 0, 0);
        chk("R2 R9 sweep aeOffset", aeOffset, ae);
        chk("R2 R8 sweep afOffset", afOffset, af);
      end

    // exhaustive wide sweep
    for (int ae = 0; ae < 8; ae++)
      for (int af = 0; af < 8; af++) begin
        loadChain(ae, af, 1, 0, 0);
        chk("R3 wide sweep aeOffset", aeOffset, ae);
        chk("R3 wide sweep afOffset", afOffset, af);
      end

    repeat (4) @(posedge rClk);
    #1;
    chk("R6 afValid settled", afValid, 1);
    chk("R6 aeValid settled", aeValid, 1);
    summary();
    $finish;
  end
endmodule